// File: doc/BRIEF.md
# x86 Effective Address Generator

This unit turns the already-decoded addressing fields of an x86 memory operand into an effective offset and the index of the segment to use. Its inputs are the 2-bit mode field, the 3-bit r/m field, the scale/index/base byte, a raw displacement, the eight general-purpose register values and an address-size select. A segment override can also be applied. It computes a 16-bit offset from the fixed base/index register pairs, or a 32-bit offset from base, scaled index and displacement. It also picks the default segment: the stack segment for frame-pointer and stack-pointer bases, and the data segment for everything else.

The address arithmetic is purely combinational. All results are captured in one output register, so a decoded operand presented on one clock edge appears on the outputs after that edge. Adding the segment base, checking limits and accessing memory are left to the stages downstream.

Top module: `ea_offset_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become zero. Otherwise each output reflects the inputs sampled at the previous rising edge, with one cycle of latency.
- R2: With `addr32`=0 and `mod_f` not 11, the r/m field picks the 16-bit sum: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. The register numbers are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. Each register is taken from the low 16 bits of its `gpr_flat` slice `[32*i +: 32]`.
- R3: With `addr32`=0, `mod_f`=00 and `rm_f`=110, the offset is the 16-bit displacement `disp_raw[15:0]` alone, with no register added.
- R4: With `mod_f`=01, the displacement is `disp_raw[7:0]` sign-extended to the address width before it is added, in both address sizes.
- R5: In 16-bit mode the sum wraps modulo 2^16 and `ea_offset[31:16]` is zero. With `mod_f`=10 the displacement is `disp_raw[15:0]`.
- R6: With `addr32`=1, the offset is base + index·2^scale + displacement, modulo 2^32. If r/m is not 100, the base is register r/m and there is no index. If r/m is 100, `sib_byte` supplies scale[7:6], index[5:3] and base[2:0]. With `mod_f`=10 the displacement is `disp_raw` in full.
- R7: A SIB index field of 100 adds no index term, whatever the scale.
- R8: With `addr32`=1 and `mod_f`=00, an r/m of 101 means the offset is `disp_raw` alone. A SIB base of 101 means no base register, and a full 32-bit displacement is added.
- R9: Without a valid override, the segment index is 2 (stack) when the base register is BP, EBP or ESP, and 3 (data) otherwise. The offset-only forms count as data.
- R10: When `seg_ovr_en`=1 and `seg_ovr_sel` is 0..5 (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5), that index is output. An override value of 6 or 7 is ignored and the default of R9 is kept.
- R11: With `mod_f`=11, `reg_operand` is 1 and the offset and segment are don't-care. For any other mode, `reg_operand` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| mod_f | input | 2 | Addressing mode field |
| rm_f | input | 3 | r/m field |
| sib_byte | input | 8 | Scale/index/base byte, used when 32-bit and r/m is 100 |
| disp_raw | input | 32 | Displacement as fetched, low bytes significant |
| gpr_flat | input | 256 | Eight 32-bit register values, register i at [32*i +: 32] |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr_sel | input | 3 | Override segment index |
| ea_offset | output | 32 | Effective offset |
| seg_idx | output | 3 | Selected segment index |
| reg_operand | output | 1 | Operand is a register, not memory |

## Verification
The bench goes after the irregular cases. It checks the 16-bit offset-only form, where a design that added BP would give a wrong offset and the stack segment. It checks a negative 8-bit displacement, which goes wrong if the displacement is zero-extended. It checks a BX+DI sum that carries past bit 15, where a missing wrap would leave bits set above bit 15. On the 32-bit side it drives an index field of 100 with a non-zero scale, where a design that indexed ESP would add a stray term. It also drives the SIB base of 101 under mode 00, where a design that read EBP would add a register and select the stack segment. Override values 6 and 7 are driven to show they cannot leak out as an illegal segment. A long random run then compares every cycle against a behavioural model.

// File: rtl/ea_gen_pkg.sv
// Package: shared segment codes and register numbers for the effective
// address generator. Assumes the usual eight-register x86 numbering.
package ea_gen_pkg;
    localparam int ADDR_W  = 32;
    localparam int NUM_GPR = 8;
    localparam int NUM_SEG = 6;

    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    localparam logic [2:0] GPR_BX = 3'd3;
    localparam logic [2:0] GPR_SP = 3'd4;
    localparam logic [2:0] GPR_BP = 3'd5;
    localparam logic [2:0] GPR_SI = 3'd6;
    localparam logic [2:0] GPR_DI = 3'd7;
endpackage

// File: rtl/ea_disp_sel.sv
// Displacement selector: chooses and extends the displacement that the
// mode/r/m/base fields call for. Assumes disp_raw holds the fetched bytes
// little-end first, so unused upper bytes are simply ignored.
module ea_disp_sel #(
    parameter int AW = 32
) (
    input  logic          addr32,
    input  logic [1:0]    mod_f,
    input  logic [2:0]    rm_f,
    input  logic [2:0]    sib_base,
    input  logic [AW-1:0] disp_raw,
    output logic [AW-1:0] disp_ext
);
    localparam int HALF_W = AW / 2;

    logic [AW-1:0] d8_sx;
    logic [AW-1:0] d16_sx;
    logic          long_only;

    // Purpose: sign-extended short forms of the displacement.
    always_comb begin
        d8_sx     = {{(AW-8){disp_raw[7]}}, disp_raw[7:0]};
        d16_sx    = {{(AW-HALF_W){disp_raw[HALF_W-1]}}, disp_raw[HALF_W-1:0]};
        long_only = (rm_f == 3'b101) || ((rm_f == 3'b100) && (sib_base == 3'b101));
    end

    // Purpose: pick the displacement for the current mode.
    always_comb begin
        unique case (mod_f)
            2'b01:   disp_ext = d8_sx;
            2'b10:   disp_ext = addr32 ? disp_raw : d16_sx;
            2'b00: begin
                if (addr32)
                    disp_ext = long_only ? disp_raw : '0;
                else
                    disp_ext = (rm_f == 3'b110) ? d16_sx : '0;
            end
            default: disp_ext = '0;
        endcase
    end
endmodule

// File: rtl/ea_calc16.sv
// 16-bit path: forms the base/index pair sum selected by r/m, adds the
// displacement and wraps to 16 bits. Flags whether BP is the base.
// Assumes mode 11 is filtered out by the caller.
module ea_calc16 #(
    parameter int AW = 32
) (
    input  logic [1:0]    mod_f,
    input  logic [2:0]    rm_f,
    input  logic [15:0]   bx_v,
    input  logic [15:0]   bp_v,
    input  logic [15:0]   si_v,
    input  logic [15:0]   di_v,
    input  logic [AW-1:0] disp_ext,
    output logic [AW-1:0] off16,
    output logic          bp_base
);
    logic [15:0] term_a;
    logic [15:0] term_b;
    logic [15:0] sum16;

    // Purpose: map r/m onto its base and index terms.
    always_comb begin
        term_a  = '0;
        term_b  = '0;
        bp_base = 1'b0;
        unique case (rm_f)
            3'b000: begin term_a = bx_v; term_b = si_v; end
            3'b001: begin term_a = bx_v; term_b = di_v; end
            3'b010: begin term_a = bp_v; term_b = si_v; bp_base = 1'b1; end
            3'b011: begin term_a = bp_v; term_b = di_v; bp_base = 1'b1; end
            3'b100: term_a = si_v;
            3'b101: term_a = di_v;
            3'b110: begin
                if (mod_f != 2'b00) begin
                    term_a  = bp_v;
                    bp_base = 1'b1;
                end
            end
            default: term_a = bx_v;
        endcase
    end

    // Purpose: wrapped 16-bit sum, zero-extended to the address width.
    always_comb begin
        sum16 = term_a + term_b + disp_ext[15:0];
        off16 = {{(AW-16){1'b0}}, sum16};
    end
endmodule

// File: rtl/ea_calc32.sv
// 32-bit path: base plus scaled index plus displacement, modulo 2^AW.
// Handles the no-index code and the no-base code. Flags a stack base.
// Assumes mode 11 is filtered out by the caller.
module ea_calc32 #(
    parameter int AW   = 32,
    parameter int NREG = 8
) (
    input  logic [1:0]               mod_f,
    input  logic [2:0]               rm_f,
    input  logic [7:0]               sib_byte,
    input  logic [NREG-1:0][AW-1:0]  gpr,
    input  logic [AW-1:0]            disp_ext,
    output logic [AW-1:0]            off32,
    output logic                     stack_base
);
    localparam logic [2:0] NO_IDX  = 3'b100;
    localparam logic [2:0] SIB_SEL = 3'b100;
    localparam logic [2:0] DISP_BS = 3'b101;

    logic          has_sib;
    logic [2:0]    base_code;
    logic [2:0]    idx_code;
    logic [1:0]    scale;
    logic          no_base;
    logic [AW-1:0] base_val;
    logic [AW-1:0] idx_val;

    // Purpose: split the fields and decide which terms exist.
    always_comb begin
        has_sib   = (rm_f == SIB_SEL);
        base_code = has_sib ? sib_byte[2:0] : rm_f;
        idx_code  = sib_byte[5:3];
        scale     = sib_byte[7:6];
        no_base   = (mod_f == 2'b00) && (base_code == DISP_BS);
        base_val  = no_base ? '0 : gpr[base_code];
        idx_val   = (has_sib && (idx_code != NO_IDX)) ? (gpr[idx_code] << scale) : '0;
    end

    // Purpose: final sum and stack-base flag.
    always_comb begin
        off32      = base_val + idx_val + disp_ext;
        stack_base = !no_base && ((base_code == ea_gen_pkg::GPR_SP) ||
                                  (base_code == ea_gen_pkg::GPR_BP));
    end
endmodule

// File: rtl/ea_offset_gen.sv
// Top: effective address generator. Combines the displacement selector,
// the 16-bit and 32-bit paths, segment selection with override screening,
// and one output register. Assumes decoded fields are stable at the edge.
module ea_offset_gen
    import ea_gen_pkg::*;
#(
    parameter int AW   = ea_gen_pkg::ADDR_W,
    parameter int NREG = ea_gen_pkg::NUM_GPR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr32,
    input  logic [1:0]         mod_f,
    input  logic [2:0]         rm_f,
    input  logic [7:0]         sib_byte,
    input  logic [AW-1:0]      disp_raw,
    input  logic [NREG*AW-1:0] gpr_flat,
    input  logic               seg_ovr_en,
    input  logic [2:0]         seg_ovr_sel,
    output logic [AW-1:0]      ea_offset,
    output logic [2:0]         seg_idx,
    output logic               reg_operand
);
    logic [NREG-1:0][AW-1:0] gpr;
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] off16;
    logic [AW-1:0] off32;
    logic          bp_base;
    logic          stack_base;
    logic          ovr_ok;
    logic [2:0]    seg_nx;
    logic [AW-1:0] off_nx;

    // Purpose: unpack the flat register bus.
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*AW +: AW];
    end

    ea_disp_sel #(.AW(AW)) u_disp (
        .addr32   (addr32),
        .mod_f    (mod_f),
        .rm_f     (rm_f),
        .sib_base (sib_byte[2:0]),
        .disp_raw (disp_raw),
        .disp_ext (disp_ext)
    );

    ea_calc16 #(.AW(AW)) u_c16 (
        .mod_f    (mod_f),
        .rm_f     (rm_f),
        .bx_v     (gpr[GPR_BX][15:0]),
        .bp_v     (gpr[GPR_BP][15:0]),
        .si_v     (gpr[GPR_SI][15:0]),
        .di_v     (gpr[GPR_DI][15:0]),
        .disp_ext (disp_ext),
        .off16    (off16),
        .bp_base  (bp_base)
    );

    ea_calc32 #(.AW(AW), .NREG(NREG)) u_c32 (
        .mod_f      (mod_f),
        .rm_f       (rm_f),
        .sib_byte   (sib_byte),
        .gpr        (gpr),
        .disp_ext   (disp_ext),
        .off32      (off32),
        .stack_base (stack_base)
    );

    // Purpose: choose the path and the segment, screening the override.
    always_comb begin
        off_nx = addr32 ? off32 : off16;
        ovr_ok = seg_ovr_en && (seg_ovr_sel < 3'(NUM_SEG));
        if (ovr_ok)
            seg_nx = seg_ovr_sel;
        else if (addr32 ? stack_base : bp_base)
            seg_nx = SEG_SS;
        else
            seg_nx = SEG_DS;
    end

    // Purpose: output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_offset   <= '0;
            seg_idx     <= '0;
            reg_operand <= 1'b0;
        end else begin
            ea_offset   <= off_nx;
            seg_idx     <= seg_nx;
            reg_operand <= (mod_f == 2'b11);
        end
    end

    // Register-operand flag follows the mode sampled one edge earlier.
    assert_regop_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (reg_operand == ($past(mod_f) == 2'b11)));

    // Segment index never leaves the legal range.
    assert_seg_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx < 3'(NUM_SEG));

    // A legal override always wins.
    assert_override_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(seg_ovr_en) && ($past(seg_ovr_sel) < 3'(NUM_SEG)))
        |-> (seg_idx == $past(seg_ovr_sel)));

    // 16-bit offsets never carry above bit 15.
    assert_wrap16_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(addr32)) |-> (ea_offset[AW-1:16] == '0));

    // Without a usable override only the stack or data segment is chosen.
    assert_default_seg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(seg_ovr_en) && ($past(seg_ovr_sel) < 3'(NUM_SEG))))
        |-> ((seg_idx == SEG_SS) || (seg_idx == SEG_DS)));
endmodule

// File: tb/ea_offset_gen_tb.sv
// Bench: behavioural reference model compared on every clock.
module ea_offset_gen_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         addr32 = 1'b0;
    logic [1:0]   mod_f = '0;
    logic [2:0]   rm_f = '0;
    logic [7:0]   sib_byte = '0;
    logic [31:0]  disp_raw = '0;
    logic [255:0] gpr_flat = '0;
    logic         seg_ovr_en = 1'b0;
    logic [2:0]   seg_ovr_sel = '0;
    logic [31:0]  ea_offset;
    logic [2:0]   seg_idx;
    logic         reg_operand;

    int total = 0;
    int bad = 0;
    logic [31:0] rv [8];

    always #2 clk = ~clk;   // 250 MHz

    ea_offset_gen u_dut (
        .clk(clk), .rst_n(rst_n), .addr32(addr32), .mod_f(mod_f), .rm_f(rm_f),
        .sib_byte(sib_byte), .disp_raw(disp_raw), .gpr_flat(gpr_flat),
        .seg_ovr_en(seg_ovr_en), .seg_ovr_sel(seg_ovr_sel),
        .ea_offset(ea_offset), .seg_idx(seg_idx), .reg_operand(reg_operand)
    );

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_regs();
        for (int i = 0; i < 8; i++) gpr_flat[32*i +: 32] = rv[i];
    endtask

    function automatic longint sx8(logic [31:0] d);
        longint v = d[7:0];
        if (v >= 128) v -= 256;
        return v;
    endfunction

    // Behavioural model: offset, segment and register flag.
    task automatic model(output longint off, output int seg, output bit regop);
        longint sum = 0;
        bit stk = 0;
        regop = (mod_f == 2'd3);
        if (!addr32) begin
            longint bx = rv[3][15:0], bp = rv[5][15:0], si = rv[6][15:0], di = rv[7][15:0];
            case (rm_f)
                0: sum = bx + si;
                1: sum = bx + di;
                2: begin sum = bp + si; stk = 1; end
                3: begin sum = bp + di; stk = 1; end
                4: sum = si;
                5: sum = di;
                6: if (mod_f != 0) begin sum = bp; stk = 1; end
                default: sum = bx;
            endcase
            if (mod_f == 1) sum += sx8(disp_raw);
            else if (mod_f == 2 || (mod_f == 0 && rm_f == 6)) sum += disp_raw[15:0];
            off = sum & 64'hFFFF;
        end else begin
            int b = (rm_f == 4) ? sib_byte[2:0] : rm_f;
            int ix = sib_byte[5:3];
            bit nob = (mod_f == 0 && b == 5);
            if (!nob) begin sum = rv[b]; stk = (b == 4 || b == 5); end
            if (rm_f == 4 && ix != 4) sum += longint'(rv[ix]) * (1 << sib_byte[7:6]);
            if (mod_f == 1) sum += sx8(disp_raw);
            else if (mod_f == 2 || nob) sum += disp_raw;
            off = sum & 64'hFFFF_FFFF;
        end
        if (seg_ovr_en && seg_ovr_sel <= 5) seg = seg_ovr_sel;
        else seg = stk ? 2 : 3;
    endtask

    // Drive one vector at a falling edge and check it one clock later.
    task automatic vec(string otag, bit a32, logic [1:0] m, logic [2:0] r,
                       logic [7:0] s, logic [31:0] d, bit oe, logic [2:0] os);
        longint eo; int es; bit er;
        string stag;
        addr32 = a32; mod_f = m; rm_f = r; sib_byte = s; disp_raw = d;
        seg_ovr_en = oe; seg_ovr_sel = os;
        load_regs();
        model(eo, es, er);
        stag = (oe && os <= 5) ? "R10" : "R9";
        @(negedge clk);
        chk("R11", reg_operand, er);
        if (!er) begin
            chk(otag, ea_offset, eo);
            chk(stag, seg_idx, es);
        end
    endtask

    initial begin
        rv[0] = 32'h0000_0010; rv[1] = 32'h0000_0200; rv[2] = 32'h0000_3000;
        rv[3] = 32'h1234_8000; rv[4] = 32'h0000_FFFE; rv[5] = 32'h0000_9000;
        rv[6] = 32'h0000_0100; rv[7] = 32'h0000_FFFE;
        load_regs();
        addr32 = 1'b1; mod_f = 2'd2; disp_raw = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: reset clears outputs
        chk("R1", ea_offset, 0); chk("R1", seg_idx, 0); chk("R1", reg_operand, 0);
        rst_n = 1'b1;

        // R2: every 16-bit pair, mode 00
        for (int r = 0; r < 8; r++) if (r != 6) vec("R2", 0, 0, 3'(r), 0, 32'h5555_5555, 0, 0);
        vec("R3", 0, 0, 6, 8'hFF, 32'hABCD_1234, 0, 0);       // disp only, DS (R3)
        vec("R4", 0, 1, 6, 0, 32'h0000_00F0, 0, 0);           // BP - 16
        vec("R5", 0, 1, 1, 0, 32'h0000_0005, 0, 0);           // BX+DI wraps
        vec("R5", 0, 2, 2, 0, 32'h0000_F000, 0, 0);           // disp16
        // R6: 32-bit base + scaled index
        vec("R6", 1, 2, 4, {2'd3, 3'd1, 3'd0}, 32'h1000_0000, 0, 0);
        vec("R6", 1, 0, 3, 0, 0, 0, 0);
        vec("R6", 1, 2, 3, 0, 32'hF000_0000, 0, 0);           // wraps mod 2^32
        vec("R7", 1, 0, 4, {2'd3, 3'd4, 3'd2}, 0, 0, 0);      // no index
        vec("R8", 1, 0, 5, 0, 32'h0040_1000, 0, 0);           // disp32 only
        vec("R8", 1, 0, 4, {2'd1, 3'd6, 3'd5}, 32'h0000_0800, 0, 0);
        vec("R4", 1, 1, 5, 0, 32'h0000_0080, 0, 0);           // EBP - 128, SS
        vec("R9", 1, 1, 4, {2'd0, 3'd4, 3'd4}, 32'h4, 0, 0);  // ESP base -> SS
        vec("R10", 0, 0, 2, 0, 0, 1, 3'd4);                   // FS override
        vec("R10", 0, 0, 2, 0, 0, 1, 3'd6);                   // ignored
        vec("R10", 1, 0, 0, 0, 0, 1, 3'd7);                   // ignored
        vec("R11", 1, 3, 2, 0, 0, 0, 0);                      // register operand

        // Random sweep (R2, R6 and the rest by category)
        for (int n = 0; n < 600; n++) begin
            bit a = n[0];
            for (int i = 0; i < 8; i++) rv[i] = $urandom;
            vec(a ? "R6" : "R2", a, 2'($urandom), 3'($urandom), 8'($urandom),
                $urandom, 1'($urandom), 3'($urandom));
        end

        // R1: reset again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", ea_offset, 0); chk("R1", seg_idx, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule